// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a 16-bit stereo PCM stream arriving on three wires: a bit clock, a word clock and a data line. It turns the stream into parallel samples. All three wires, and the two mode pins, are asynchronous to the system clock `clk`. They pass through a synchronizer, and every bit is taken when the synchronized bit clock rises.

The `fmt_i2s` pin selects the framing. When it is low, the framing is right-justified: the word ends on the last bit before the word clock changes level, and any bits ahead of it are discarded. When it is high, the framing is I2S: the word starts one bit clock after the level change, and any bits after the sixteenth are discarded. The `lr_swap` pin selects which word-clock level marks the left channel.

Once a right word has arrived after a left word, the left and right samples are presented together with a one-cycle strobe. An active-low flag reports that the data line has carried nothing but zeros for a long run of bit clocks.

Top module: `pcm_serial_rx`

## Requirements
- R1: Each sample is 16 bits, sent MSB first. The data line is taken on each rising edge of the bit clock.
- R2: With `fmt_i2s`=0 (right-justified), the LSB of a word is the bit taken on the last rising bit-clock edge before the word clock changes level. Only the 16 bits just before that change are kept, so earlier bits in the slot have no effect.
- R3: With `fmt_i2s`=1 (I2S), the MSB is the bit taken on the second rising bit-clock edge after the word-clock level change. The following 15 edges carry the rest of the word, and any later bits in the slot have no effect.
- R4: The level of `fmt_i2s` alone selects between the framings of R2 and R3. Both framings accept slots of 16 and of 32 bit clocks.
- R5: With `lr_swap`=0, a high word clock carries the left channel and a low one the right. With `lr_swap`=1, the mapping is reversed.
- R6: `valid_o` is high for exactly one `clk` cycle when a right word completes after a left word. `left_o` and `right_o` then hold that pair and change only on such a pulse. A right word with no left word before it produces no pulse.
- R7: `zero_n_o` goes low once the data line has been 0 on more than `ZERO_LIMIT` consecutive rising bit-clock edges (default 65535). It stays high after exactly `ZERO_LIMIT` such edges.
- R8: A 1 on the data line raises `zero_n_o` on that same edge and restarts the run count. The count saturates, so the flag stays low however long the run of zeros lasts.
- R9: While reset is held, and after it is released, `valid_o` is 0, `left_o` and `right_o` are 0, and `zero_n_o` is 1. The first word clock seen after reset only arms the framing and yields no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s | input | 1 | Framing select: 0 right-justified, 1 I2S |
| lr_swap | input | 1 | Word-clock polarity: 0 high is left, 1 low is left |
| bck | input | 1 | Serial bit clock |
| lrck | input | 1 | Word clock, one period per stereo frame |
| sdata | input | 1 | Serial data |
| left_o | output | 16 | Left sample of the last complete frame |
| right_o | output | 16 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| zero_n_o | output | 1 | Low after a long run of zero data bits |

## Verification
In right-justified mode, a right word completes on the same bit-clock edge that samples the first bit of the next slot. That edge can therefore deliver the frame strobe and release the zero flag at once. The bench saturates the zero counter with a long run of zero bits, then sends an all-zero left/right pair followed by a slot whose MSB is 1. It judges the cycle by requiring a single captured pair of zeros and a high flag.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int SAMPLE_W = 16;

  typedef enum logic {
    FMT_RJ  = 1'b0,
    FMT_I2S = 1'b1
  } fmt_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] data;
    logic                is_left;
  } word_t;

endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/psr_deframe.sv
module psr_deframe
  import psr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_rise,
  input  logic  lr_lvl,
  input  logic  din,
  input  fmt_e  fmt,
  input  logic  lr_swap,
  output word_t word_q,
  output logic  word_stb
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                lr_prev_q, lr_prev_d;
  logic                seen_q, seen_d;
  logic                armed_q, armed_d;
  logic                slot_left_q, slot_left_d;
  word_t               word_d;
  logic                stb_d;

  logic                change;
  logic [SAMPLE_W-1:0] shifted;

  always_comb begin
    shreg_d     = shreg_q;
    cnt_d       = cnt_q;
    lr_prev_d   = lr_prev_q;
    seen_d      = seen_q;
    armed_d     = armed_q;
    slot_left_d = slot_left_q;
    word_d      = word_q;
    stb_d       = 1'b0;
    change      = seen_q && (lr_lvl != lr_prev_q);
    shifted     = {shreg_q[SAMPLE_W-2:0], din};

    if (bit_rise) begin
      if (fmt == FMT_RJ) begin
        if (change && armed_q) begin
          stb_d          = 1'b1;
          word_d.data    = shreg_q;
          word_d.is_left = lr_prev_q ^ lr_swap;
        end
        shreg_d = shifted;
      end else begin
        if (armed_q && (cnt_q != CNT_FULL)) begin
          shreg_d = shifted;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            stb_d          = 1'b1;
            word_d.data    = shifted;
            word_d.is_left = slot_left_q;
          end
        end
      end

      if (change) begin
        armed_d     = 1'b1;
        cnt_d       = '0;
        slot_left_d = lr_lvl ^ lr_swap;
      end
      lr_prev_d = lr_lvl;
      seen_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q     <= '0;
      cnt_q       <= '0;
      lr_prev_q   <= 1'b0;
      seen_q      <= 1'b0;
      armed_q     <= 1'b0;
      slot_left_q <= 1'b0;
      word_q      <= '0;
      word_stb    <= 1'b0;
    end else begin
      shreg_q     <= shreg_d;
      cnt_q       <= cnt_d;
      lr_prev_q   <= lr_prev_d;
      seen_q      <= seen_d;
      armed_q     <= armed_d;
      slot_left_q <= slot_left_d;
      word_q      <= word_d;
      word_stb    <= stb_d;
    end
  end

endmodule

// File: rtl/psr_zero_det.sv
module psr_zero_det #(
  parameter int ZERO_LIMIT = 65535
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_rise,
  input  logic din,
  output logic zero_n
);

  localparam int CW = $clog2(ZERO_LIMIT + 2);
  localparam logic [CW-1:0] RUN_SAT = CW'(ZERO_LIMIT + 1);
  localparam logic [CW-1:0] RUN_LIM = CW'(ZERO_LIMIT);

  logic [CW-1:0] run_q, run_d;
  logic          zero_n_d;

  always_comb begin
    run_d    = run_q;
    zero_n_d = zero_n;
    if (bit_rise) begin
      if (din) begin
        run_d    = '0;
        zero_n_d = 1'b1;
      end else begin
        if (run_q != RUN_SAT) run_d = run_q + 1'b1;
        zero_n_d = (run_d <= RUN_LIM);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      zero_n <= 1'b1;
    end else begin
      run_q  <= run_d;
      zero_n <= zero_n_d;
    end
  end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import psr_pkg::*;
#(
  parameter int ZERO_LIMIT  = 65535,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt_i2s,
  input  logic        lr_swap,
  input  logic        bck,
  input  logic        lrck,
  input  logic        sdata,
  output logic [15:0] left_o,
  output logic [15:0] right_o,
  output logic        valid_o,
  output logic        zero_n_o
);

  localparam int IN_W = 5;

  logic            rst_n_i;
  logic [IN_W-1:0] raw_in, sync_in;
  logic            s_fmt, s_swap, s_bck, s_lr, s_data;
  logic            bck_prev_q;
  logic            bit_rise;
  word_t           word;
  logic            word_stb;

  logic [SAMPLE_W-1:0] left_hold_q, left_hold_d;
  logic                have_left_q, have_left_d;
  logic [SAMPLE_W-1:0] left_d, right_d;
  logic                valid_d;

  psr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign raw_in = {fmt_i2s, lr_swap, bck, lrck, sdata};

  psr_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .async_i (raw_in),
    .sync_o  (sync_in)
  );

  assign {s_fmt, s_swap, s_bck, s_lr, s_data} = sync_in;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) bck_prev_q <= 1'b0;
    else          bck_prev_q <= s_bck;
  end

  assign bit_rise = s_bck & ~bck_prev_q;

  psr_deframe u_deframe (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .bit_rise (bit_rise),
    .lr_lvl   (s_lr),
    .din      (s_data),
    .fmt      (fmt_e'(s_fmt)),
    .lr_swap  (s_swap),
    .word_q   (word),
    .word_stb (word_stb)
  );

  psr_zero_det #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .bit_rise (bit_rise),
    .din      (s_data),
    .zero_n   (zero_n_o)
  );

  always_comb begin
    left_hold_d = left_hold_q;
    have_left_d = have_left_q;
    left_d      = left_o;
    right_d     = right_o;
    valid_d     = 1'b0;
    if (word_stb) begin
      if (word.is_left) begin
        left_hold_d = word.data;
        have_left_d = 1'b1;
      end else if (have_left_q) begin
        left_d      = left_hold_q;
        right_d     = word.data;
        valid_d     = 1'b1;
        have_left_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      left_hold_q <= left_hold_d;
      have_left_q <= have_left_d;
      left_o      <= left_d;
      right_o     <= right_d;
      valid_o     <= valid_d;
    end
  end

endmodule

// File: rtl/psr_checker.sv
module psr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_rise,
  input logic        sbit,
  input logic        word_stb,
  input logic        valid_o,
  input logic [15:0] left_o,
  input logic [15:0] right_o,
  input logic        zero_n_o
);

  // R1: words complete only on a bit-clock rising edge
  p_word_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $past(bit_rise));

  // R6: the strobe lasts one cycle
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6: samples change only with the strobe
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o) |-> ($stable(left_o) && $stable(right_o)));

  // R7: the flag falls only on a zero bit at a bit-clock edge
  p_zero_fall_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zero_n_o) |-> $past(bit_rise && !sbit));

  // R8: the flag rises only on a one bit at a bit-clock edge
  p_zero_rise_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_n_o) |-> $past(bit_rise && sbit));

endmodule

bind pcm_serial_rx psr_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_rise (bit_rise),
  .sbit     (s_data),
  .word_stb (word_stb),
  .valid_o  (valid_o),
  .left_o   (left_o),
  .right_o  (right_o),
  .zero_n_o (zero_n_o)
);

// File: tb/pcm_serial_rx_test.sv
module pcm_serial_rx_test;

  localparam int ZL = 40;
  localparam int HB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_i2s = 1'b0;
  logic        lr_swap = 1'b0;
  logic        bck = 1'b0;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [15:0] left_o, right_o;
  logic        valid_o, zero_n_o;

  int total = 0;
  int bad = 0;
  int cap_total = 0;
  logic [15:0] cap_l [64];
  logic [15:0] cap_r [64];
  logic prev_lsb = 1'b0;

  always #10 clk = ~clk;

  pcm_serial_rx #(.ZERO_LIMIT(ZL)) uut (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .lr_swap(lr_swap),
    .bck(bck), .lrck(lrck), .sdata(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .zero_n_o(zero_n_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o && cap_total < 64) begin
      cap_l[cap_total] = left_o;
      cap_r[cap_total] = right_o;
      cap_total = cap_total + 1;
    end
  end

  // {fmt, swap, slot32, left, right}
  localparam logic [34:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 16'hA5C3, 16'h3C5A},
    {1'b0, 1'b1, 1'b0, 16'h1234, 16'hFEDC},
    {1'b0, 1'b0, 1'b1, 16'h8001, 16'h7FFE},
    {1'b1, 1'b0, 1'b0, 16'h8000, 16'h0001},
    {1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 1'b1, 16'h55AA, 16'hAA55},
    {1'b0, 1'b1, 1'b1, 16'h0F0F, 16'hF0F0},
    {1'b1, 1'b1, 1'b0, 16'hC001, 16'h4003}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic lr, input logic d);
    @(negedge clk);
    lrck  = lr;
    sdata = d;
    repeat (HB) @(negedge clk);
    bck = 1'b1;
    repeat (HB) @(negedge clk);
    bck = 1'b0;
  endtask

  task automatic do_reset(input logic f, input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    fmt_i2s = f;
    lr_swap = s;
    bck = 1'b0;
    sdata = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    prev_lsb = 1'b0;
  endtask

  task automatic send_slot(input logic is_left, input logic [15:0] w, input int slot);
    logic lr;
    logic b;
    lr = is_left ^ lr_swap;
    for (int i = 0; i < slot; i++) begin
      if (!fmt_i2s) begin
        b = (i >= slot - 16) ? w[slot-1-i] : 1'b1;
      end else begin
        if (i == 0)       b = prev_lsb;
        else if (i <= 16) b = w[16-i];
        else              b = 1'b1;
      end
      bit_cycle(lr, b);
    end
    prev_lsb = w[0];
  endtask

  task automatic run_vec(input logic [34:0] v);
    int base;
    int slot;
    slot = v[32] ? 32 : 16;
    do_reset(v[34], v[33]);
    base = cap_total;
    bit_cycle(1'b0 ^ v[33], 1'b0);
    bit_cycle(1'b0 ^ v[33], 1'b0);
    send_slot(1'b1, v[31:16], slot);
    send_slot(1'b0, v[15:0], slot);
    send_slot(1'b1, 16'h8001, slot);
    repeat (8) @(negedge clk);
    // R1 R2 R3 R4 R5 R6: one pair per frame with the right mapping
    check("R6 pair count", cap_total - base, 1);
    check(v[34] ? "R3 R5 left" : "R2 R5 left", {16'h0, cap_l[base]}, {16'h0, v[31:16]});
    check(v[34] ? "R3 R4 right" : "R2 R4 right", {16'h0, cap_r[base]}, {16'h0, v[15:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R9: held in reset
    check("R9 valid in reset", {31'h0, valid_o}, 0);
    check("R9 zero flag in reset", {31'h0, zero_n_o}, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 left after reset", {16'h0, left_o}, 0);
    check("R9 right after reset", {16'h0, right_o}, 0);

    for (int k = 0; k < 8; k++) run_vec(VEC[k]);

    // R6 R9: right word without a preceding left word is dropped
    do_reset(1'b0, 1'b0);
    base = cap_total;
    bit_cycle(1'b1, 1'b0);
    send_slot(1'b0, 16'h1111, 16);
    send_slot(1'b1, 16'h2222, 16);
    send_slot(1'b0, 16'h3333, 16);
    send_slot(1'b1, 16'h8000, 16);
    repeat (8) @(negedge clk);
    check("R6 lone right dropped count", cap_total - base, 1);
    check("R6 lone right dropped left", {16'h0, cap_l[base]}, 32'h2222);
    check("R6 lone right dropped right", {16'h0, cap_r[base]}, 32'h3333);

    // R7 R8: zero-run boundary, saturation and release
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < ZL; i++) bit_cycle(1'b0, 1'b0);
    check("R7 flag high at limit", {31'h0, zero_n_o}, 1);
    bit_cycle(1'b0, 1'b0);
    check("R7 flag low past limit", {31'h0, zero_n_o}, 0);
    for (int i = 0; i < 3 * ZL; i++) bit_cycle(1'b0, 1'b0);
    check("R8 flag stays low when saturated", {31'h0, zero_n_o}, 0);
    bit_cycle(1'b0, 1'b1);
    check("R8 one bit releases flag", {31'h0, zero_n_o}, 1);
    for (int i = 0; i < ZL; i++) bit_cycle(1'b0, 1'b0);
    check("R8 count restarted", {31'h0, zero_n_o}, 1);
    bit_cycle(1'b0, 1'b0);
    check("R8 low again after restart", {31'h0, zero_n_o}, 0);

    // R6 R8: strobe and flag release on the same bit-clock edge
    for (int i = 0; i < ZL; i++) bit_cycle(1'b0, 1'b0);
    base = cap_total;
    send_slot(1'b1, 16'h0000, 16);
    send_slot(1'b0, 16'h0000, 16);
    check("R8 still low before release", {31'h0, zero_n_o}, 0);
    send_slot(1'b1, 16'h8000, 16);
    repeat (8) @(negedge clk);
    check("R6 coincident pair count", cap_total - base, 1);
    check("R6 coincident pair value", {cap_l[base], cap_r[base]}, 32'h0);
    check("R8 coincident release", {31'h0, zero_n_o}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule